// File: doc/BRIEF.md
# Tick Compare Timer Cluster

This block holds a small set of free-running cycle counters, each paired with a one-shot compare limit, as used for per-core tick and system-tick interrupt sources. Each written word is one bit wider than the count. Its most significant bit is a control flag and the lower bits are the value. The flag is a single per-channel "disabled" state. It is set by writing either the counter or the limit. On counter reads it comes back in the top bit, where it marks the count as not for user reading. It also suppresses the match interrupt.

When a channel's count reaches its armed expiry point and the channel is enabled, the channel raises a one-cycle match pulse. This pulse sets a designated soft-interrupt bit and wakes the core. Channel 0 is the processor tick and drives the timer soft-interrupt bit. Every other channel, such as the system tick and the hypervisor tick, drives the shared system-timer bit. A limit is armed once and disarms itself when it is reached. A zero limit never arms. A limit that is already at or behind the count fires on the next tick rather than waiting for a full wrap.

Top module: `tct_cluster`

## Requirements
- R1: After reset every channel reads back a zero count with the flag bit (bit VAL_W) set, and match_o, softint_set and wake_o are all zero.
- R2: A counter write loads the low VAL_W bits as the count and the top bit as the disabled flag. A read returns {flag, count} from the cycle after the write.
- R3: With tick_en high and no counter write, the count rises by one per clock and wraps from all-ones to zero. With tick_en low it holds. A counter write takes precedence over the increment.
- R4: With an enabled limit L greater than the count, the match pulse appears in the cycle after the count reads L.
- R5: A limit write whose low VAL_W bits are zero disarms the channel, and no match follows from it.
- R6: A limit write with the top bit set sets the disabled flag, which reads back in bit VAL_W, and cancels any pending expiry. A later enabled limit write re-arms the channel.
- R7: A limit at or below the count seen after the write moves the expiry to that count plus one, so the match follows after one tick.
- R8: If the flag is set when the count reaches an armed expiry, the expiry is consumed without a match pulse.
- R9: Each armed limit produces at most one match pulse, lasting one cycle. No second pulse follows, even after the counter wraps, until the limit is written again.
- R10: A match on channel 0 sets softint_set bit TICK_BIT, and a match on any other channel sets bit STICK_BIT. All other bits stay zero, and wake_o pulses in the same cycle as any match.
- R11: When the counter and the limit are written in the same cycle, the limit is compared against the newly written count, and the limit's flag bit decides the final disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable shared by all channels |
| cnt_we | input | NCH | Per-channel counter write strobe |
| cnt_wdata | input | NCH x (VAL_W+1) | Counter write word: {flag, count} |
| lim_we | input | NCH | Per-channel limit write strobe |
| lim_wdata | input | NCH x (VAL_W+1) | Limit write word: {flag, limit} |
| rd_data | output | NCH x (VAL_W+1) | Counter read: {disabled flag, count} |
| match_o | output | NCH | One-cycle match pulse per channel |
| softint_set | output | SI_W | Soft-interrupt set pulses, bits TICK_BIT and STICK_BIT |
| wake_o | output | 1 | Core wake pulse on any match |

## Verification
The bench sweeps the start count and every limit value on a 6-bit channel.

- Limits equal to or below the count are covered. A design that compared only for equality would then wait a full wrap instead of firing after one tick.
- A zero limit is covered. A design that armed on it would fire when the count wrapped to zero.
- Limits just before the wrap point are covered, which exposes an expiry that fails to wrap with the count.

The directed cases target the remaining hazards:

- The flag set while an expiry is pending: a leak would show as a stray pulse.
- A consumed expiry followed by a count rewind: a second pulse would reveal a timer that did not disarm.
- Same-cycle counter and limit writes: comparing against the stale count would shift the match by the difference.
- Simultaneous matches on the tick channel and the system channels: these must land on two distinct soft-interrupt bits.

// File: rtl/tct_pkg.sv
package tct_pkg;

    // Which soft-interrupt source a channel feeds.
    typedef enum logic {
        ROLE_TICK = 1'b0,
        ROLE_SYS  = 1'b1
    } chan_role_e;

    localparam int DEF_VAL_W     = 63;
    localparam int DEF_NCH       = 3;
    localparam int DEF_SI_W      = 17;
    localparam int DEF_TICK_BIT  = 0;
    localparam int DEF_STICK_BIT = 16;

    // Channel 0 is the processor tick; every other channel is a system timer.
    function automatic chan_role_e role_of(input int idx);
        return (idx == 0) ? ROLE_TICK : ROLE_SYS;
    endfunction

    function automatic int softint_bit_of(input int idx, input int tick_bit, input int stick_bit);
        return (role_of(idx) == ROLE_TICK) ? tick_bit : stick_bit;
    endfunction

endpackage

// File: rtl/tct_channel.sv
module tct_channel #(
    parameter int VAL_W = tct_pkg::DEF_VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_we,
    input  logic [VAL_W:0]   cnt_wdata,
    input  logic             lim_we,
    input  logic [VAL_W:0]   lim_wdata,
    output logic [VAL_W:0]   rd_data,
    output logic             fire_o
);

    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic [VAL_W-1:0] expiry;
        logic             armed;
        logic             dis;
        logic             fire;
    } chan_st_t;

    chan_st_t         st_q, st_d;
    logic             hit;
    logic [VAL_W-1:0] lim_val;
    logic [VAL_W-1:0] cnt_ref;

    always_comb begin
        st_d       = st_q;
        st_d.fire  = 1'b0;
        lim_val    = lim_wdata[VAL_W-1:0];

        // Expiry reached: consume the arm; only an enabled channel pulses.
        hit = st_q.armed && (st_q.cnt == st_q.expiry);
        if (hit) begin
            st_d.armed = 1'b0;
            st_d.fire  = !st_q.dis;
        end

        // Count path: a write overrides the increment.
        if (cnt_we) begin
            st_d.cnt = cnt_wdata[VAL_W-1:0];
            st_d.dis = cnt_wdata[VAL_W];
        end else if (tick_en) begin
            st_d.cnt = st_q.cnt + ONE;
        end

        // The limit is judged against the count visible next cycle.
        cnt_ref = st_d.cnt;
        if (lim_we) begin
            st_d.dis = lim_wdata[VAL_W];
            if ((lim_val == '0) || lim_wdata[VAL_W]) begin
                st_d.armed = 1'b0;
            end else begin
                st_d.armed  = 1'b1;
                st_d.expiry = (lim_val > cnt_ref) ? lim_val : (cnt_ref + ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.expiry <= '0;
            st_q.armed  <= 1'b0;
            st_q.dis    <= 1'b1;
            st_q.fire   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = {st_q.dis, st_q.cnt};
    assign fire_o  = st_q.fire;

endmodule

// File: rtl/tct_softint_map.sv
module tct_softint_map #(
    parameter int NCH       = tct_pkg::DEF_NCH,
    parameter int SI_W      = tct_pkg::DEF_SI_W,
    parameter int TICK_BIT  = tct_pkg::DEF_TICK_BIT,
    parameter int STICK_BIT = tct_pkg::DEF_STICK_BIT
) (
    input  logic [NCH-1:0]  fire,
    output logic [SI_W-1:0] softint_set,
    output logic            wake_o
);

    always_comb begin
        softint_set = '0;
        for (int i = 0; i < NCH; i++) begin
            if (fire[i]) begin
                softint_set[tct_pkg::softint_bit_of(i, TICK_BIT, STICK_BIT)] = 1'b1;
            end
        end
        wake_o = |fire;
    end

endmodule

// File: rtl/tct_cluster.sv
module tct_cluster #(
    parameter int VAL_W     = tct_pkg::DEF_VAL_W,
    parameter int NCH       = tct_pkg::DEF_NCH,
    parameter int SI_W      = tct_pkg::DEF_SI_W,
    parameter int TICK_BIT  = tct_pkg::DEF_TICK_BIT,
    parameter int STICK_BIT = tct_pkg::DEF_STICK_BIT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_en,
    input  logic [NCH-1:0]            cnt_we,
    input  logic [NCH-1:0][VAL_W:0]   cnt_wdata,
    input  logic [NCH-1:0]            lim_we,
    input  logic [NCH-1:0][VAL_W:0]   lim_wdata,
    output logic [NCH-1:0][VAL_W:0]   rd_data,
    output logic [NCH-1:0]            match_o,
    output logic [SI_W-1:0]           softint_set,
    output logic                      wake_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tct_channel #(
            .VAL_W (VAL_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .cnt_we    (cnt_we[g]),
            .cnt_wdata (cnt_wdata[g]),
            .lim_we    (lim_we[g]),
            .lim_wdata (lim_wdata[g]),
            .rd_data   (rd_data[g]),
            .fire_o    (match_o[g])
        );
    end

    tct_softint_map #(
        .NCH       (NCH),
        .SI_W      (SI_W),
        .TICK_BIT  (TICK_BIT),
        .STICK_BIT (STICK_BIT)
    ) u_map (
        .fire        (match_o),
        .softint_set (softint_set),
        .wake_o      (wake_o)
    );

endmodule

// File: rtl/tct_cluster_chk.sv
module tct_cluster_chk #(
    parameter int VAL_W     = tct_pkg::DEF_VAL_W,
    parameter int NCH       = tct_pkg::DEF_NCH,
    parameter int SI_W      = tct_pkg::DEF_SI_W,
    parameter int TICK_BIT  = tct_pkg::DEF_TICK_BIT,
    parameter int STICK_BIT = tct_pkg::DEF_STICK_BIT
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_en,
    input logic [NCH-1:0]          cnt_we,
    input logic [NCH-1:0][VAL_W:0] cnt_wdata,
    input logic [NCH-1:0]          lim_we,
    input logic [NCH-1:0][VAL_W:0] lim_wdata,
    input logic [NCH-1:0][VAL_W:0] rd_data,
    input logic [NCH-1:0]          match_o,
    input logic [SI_W-1:0]         softint_set,
    input logic                    wake_o
);

    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        localparam int BIT_G = tct_pkg::softint_bit_of(g, TICK_BIT, STICK_BIT);

        p_cnt_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_we[g] && !lim_we[g] |=> rd_data[g] == $past(cnt_wdata[g]));

        p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_we[g] && tick_en |=> rd_data[g][VAL_W-1:0] == ($past(rd_data[g][VAL_W-1:0]) + ONE));

        p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_we[g] && !tick_en |=> $stable(rd_data[g][VAL_W-1:0]));

        p_zero_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            lim_we[g] && (lim_wdata[g][VAL_W-1:0] == '0) |=> ##1 !match_o[g]);

        p_dis_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            lim_we[g] && lim_wdata[g][VAL_W] |=> rd_data[g][VAL_W] ##1 !match_o[g]);

        p_no_match_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[g] |-> !$past(rd_data[g][VAL_W]));

        p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[g] |=> !match_o[g]);

        p_softint_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[g] |-> softint_set[BIT_G] && wake_o);
    end

    p_quiet_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> softint_set == '0);

    p_softint_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(softint_set) <= 2);

endmodule

bind tct_cluster tct_cluster_chk #(
    .VAL_W     (VAL_W),
    .NCH       (NCH),
    .SI_W      (SI_W),
    .TICK_BIT  (TICK_BIT),
    .STICK_BIT (STICK_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cnt_we      (cnt_we),
    .cnt_wdata   (cnt_wdata),
    .lim_we      (lim_we),
    .lim_wdata   (lim_wdata),
    .rd_data     (rd_data),
    .match_o     (match_o),
    .softint_set (softint_set),
    .wake_o      (wake_o)
);

// File: tb/test_tct_cluster.sv
`timescale 1ns/1ps
module test_tct_cluster;

    localparam int VW  = 6;
    localparam int NC  = 3;
    localparam int SW  = 17;
    localparam int TB0 = 0;
    localparam int TB1 = 16;
    localparam int MOD = 64;

    logic                 clk;
    logic                 rst_n;
    logic                 tick_en;
    logic [NC-1:0]        cnt_we;
    logic [NC-1:0][VW:0]  cnt_wdata;
    logic [NC-1:0]        lim_we;
    logic [NC-1:0][VW:0]  lim_wdata;
    logic [NC-1:0][VW:0]  rd_data;
    logic [NC-1:0]        match_o;
    logic [SW-1:0]        softint_set;
    logic                 wake_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    tct_cluster #(
        .VAL_W(VW), .NCH(NC), .SI_W(SW), .TICK_BIT(TB0), .STICK_BIT(TB1)
    ) i_tct_cluster (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .lim_we(lim_we), .lim_wdata(lim_wdata),
        .rd_data(rd_data), .match_o(match_o),
        .softint_set(softint_set), .wake_o(wake_o)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr_cnt(input int ch, input bit f, input int v);
        @(negedge clk);
        cnt_we[ch]    = 1'b1;
        cnt_wdata[ch] = {f, 6'(v)};
        @(negedge clk);
        cnt_we[ch]    = 1'b0;
    endtask

    task automatic wr_lim(input int ch, input bit f, input int v);
        @(negedge clk);
        lim_we[ch]    = 1'b1;
        lim_wdata[ch] = {f, 6'(v)};
        @(negedge clk);
        lim_we[ch]    = 1'b0;
    endtask

    task automatic wr_both(input int ch, input bit fc, input int vc, input bit fl, input int vl);
        @(negedge clk);
        cnt_we[ch]    = 1'b1;
        cnt_wdata[ch] = {fc, 6'(vc)};
        lim_we[ch]    = 1'b1;
        lim_wdata[ch] = {fl, 6'(vl)};
        @(negedge clk);
        cnt_we[ch]    = 1'b0;
        lim_we[ch]    = 1'b0;
    endtask

    // Tick n times and expect channel ch to pulse exactly at tick number at_j (0 = never).
    task automatic run_expect(input string req, input int ch, input int n, input int at_j);
        int hits = 0;
        tick_en = 1'b1;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (match_o[ch]) begin
                hits++;
                check(req, "match tick", j, at_j);
            end
        end
        tick_en = 1'b0;
        check(req, "match count", hits, (at_j == 0) ? 0 : 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=190000 expected=fewer cycles");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        tick_en   = 1'b0;
        cnt_we    = '0;
        lim_we    = '0;
        cnt_wdata = '0;
        lim_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int ch = 0; ch < NC; ch++) check("R1", "rd_data", rd_data[ch], 7'h40);
        check("R1", "match", match_o, 0);
        check("R1", "softint", softint_set, 0);
        check("R1", "wake", wake_o, 0);

        // R2 counter writes with alternating flag
        for (int v = 0; v < MOD; v++) begin
            wr_cnt(0, v[0], v);
            check("R2", "read after write", rd_data[0], {v[0], 6'(v)});
        end
        wr_cnt(2, 1'b1, 45);
        check("R2", "ch2 read", rd_data[2], {1'b1, 6'd45});

        // R3 increment, wrap, hold, write over increment
        wr_cnt(1, 1'b0, 60);
        tick_en = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check("R3", "count step", rd_data[1][5:0], (60 + k) % MOD);
        end
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R3", "count hold", rd_data[1][5:0], 4);
        tick_en = 1'b1;
        wr_cnt(1, 1'b0, 17);
        check("R3", "write beats increment", rd_data[1][5:0], 17);
        tick_en = 1'b0;

        // R4 R5 R7 R9 R10 sweep on channel 0
        for (int c = 0; c < MOD; c += 7) begin
            for (int l = 0; l < MOD; l++) begin
                int    d;
                string req;
                tick_en = 1'b0;
                wr_cnt(0, 1'b0, c);
                wr_lim(0, 1'b0, l);
                d   = (l == 0) ? -1 : ((l > c) ? (l - c) : 1);
                req = (l == 0) ? "R5" : ((l > c) ? "R4" : "R7");
                tick_en = 1'b1;
                for (int j = 1; j <= 70; j++) begin
                    bit em;
                    @(negedge clk);
                    em = (l != 0) && (j == d + 1);
                    check((j > d + 1 && l != 0) ? "R9" : req, "match ch0", match_o[0], em);
                    check("R10", "softint tick bit", softint_set, em ? 17'h00001 : 17'h0);
                    check("R10", "wake", wake_o, em);
                end
                tick_en = 1'b0;
            end
        end

        // R6 flagged limit cancels, re-arm afterwards
        wr_cnt(0, 1'b0, 5);
        wr_lim(0, 1'b0, 9);
        wr_lim(0, 1'b1, 9);
        check("R6", "flag readback", rd_data[0][6], 1);
        run_expect("R6", 0, 70, 0);
        wr_cnt(0, 1'b0, 5);
        wr_lim(0, 1'b1, 9);
        wr_lim(0, 1'b0, 12);
        check("R6", "flag cleared", rd_data[0][6], 0);
        run_expect("R6", 0, 20, 8);

        // R8 flag set while armed, then R9 consumed arm
        wr_cnt(0, 1'b0, 20);
        wr_lim(0, 1'b0, 24);
        wr_cnt(0, 1'b1, 20);
        run_expect("R8", 0, 10, 0);
        check("R8", "flag still set", rd_data[0][6], 1);
        wr_cnt(0, 1'b0, 20);
        run_expect("R9", 0, 10, 0);

        // R11 same-cycle writes
        wr_both(0, 1'b0, 30, 1'b0, 30);
        check("R11", "read", rd_data[0], {1'b0, 6'd30});
        run_expect("R11", 0, 10, 2);
        wr_both(0, 1'b0, 30, 1'b0, 35);
        run_expect("R11", 0, 10, 6);
        wr_both(0, 1'b0, 30, 1'b1, 35);
        check("R11", "limit flag wins", rd_data[0][6], 1);
        run_expect("R11", 0, 10, 0);
        wr_both(0, 1'b1, 30, 1'b0, 33);
        check("R11", "limit flag clears", rd_data[0][6], 0);
        run_expect("R11", 0, 10, 4);

        // R10 routing for all channels together and system channels alone
        for (int ch = 0; ch < NC; ch++) begin
            wr_cnt(ch, 1'b0, 40);
            wr_lim(ch, 1'b0, 43);
        end
        tick_en = 1'b1;
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            check("R10", "all match", match_o, (j == 4) ? 3'b111 : 3'b000);
            check("R10", "both bits", softint_set, (j == 4) ? 17'h10001 : 17'h0);
            check("R10", "wake all", wake_o, j == 4);
        end
        tick_en = 1'b0;
        for (int ch = 1; ch < NC; ch++) begin
            wr_cnt(ch, 1'b0, 0);
            wr_lim(ch, 1'b0, 2);
            tick_en = 1'b1;
            for (int j = 1; j <= 5; j++) begin
                @(negedge clk);
                check("R10", "sys match", match_o, (j == 3) ? (3'b001 << ch) : 3'b000);
                check("R10", "sys bit", softint_set, (j == 3) ? 17'h10000 : 17'h0);
                check("R10", "sys wake", wake_o, j == 3);
            end
            tick_en = 1'b0;
        end

        finish_run();
    end

endmodule